// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block puts one low-speed USB packet on the differential pair. A start strobe arrives with a byte count that includes the leading sync byte. The block then takes ownership of the bus. It first presents the idle level with its drivers off, and then turns the drivers on while still at idle. It sends the sync byte and the caller's bytes least significant bit first, with NRZI coding and bit stuffing. It closes with the end-of-packet signalling and then switches its drivers off. Payload bytes are read through a zero-latency read port: the block shows the index it wants and samples the byte on the same cycle.

The block also keeps the device's bus address. Software-side logic loads a pending value at any time. That value becomes the active address only when a packet flagged as data has been fully sent. Handshake replies never change the active address. Bit length is a whole number of clock cycles, because the bus tolerates a rate error of about 1.5 percent and no fractional correction is needed. The first line transition follows the start strobe within three clock cycles, which is well inside the reply window the bus allows after a received packet.

Top module: `usb_ls_tx`

## Requirements
- R1: A start strobe is accepted only in idle and only when the byte count is from MIN_BYTES (2) to MAX_BYTES (12) inclusive. Any other count leaves the block idle, with busy low and drivers off.
- R2: After an accepted start, the block spends one cycle driving the J level (dp=0, dm=1) with oe low, then one cycle at J with oe high. The first sync bit appears on the next cycle.
- R3: The first byte sent is 0x80. Bytes at indices 1 to count-1 follow in index order, each least significant bit first. byte_idx_o shows the index that byte_i is sampled for.
- R4: Each bit slot lasts CLKS_PER_BIT cycles. A 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0). A 1 bit holds the level. The first toggle starts from J. Both lines are never high together.
- R5: After STUFF_RUN (6) consecutive 1 bits, an extra toggle slot is sent before the next bit. The run count includes the sync byte's bits, and every 0 bit or stuffed slot resets it.
- R6: If the packet's last bits complete a run of six 1 bits, the stuffed toggle slot is still sent before the end of packet.
- R7: The end of packet is both lines low with oe high for two bit slots, then J for one slot. After that, oe drops and both lines are driven low.
- R8: busy_o is high from the cycle after an accepted start until the drivers are released. A start strobe while busy has no effect on the line sequence.
- R9: done_o pulses high for exactly one cycle, in the first cycle after the drivers are released.
- R10: dev_addr_o resets to 0. A write to addr_wr_i/addr_i updates only the pending address. The pending value moves to dev_addr_o at the done pulse, and only if data_pkt_i was high at the accepted start.
- R11: Out of reset, oe_o, dp_o, dm_o, busy_o and done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| byte_cnt_i | input | CNT_W | Bytes to send, sync byte included |
| data_pkt_i | input | 1 | High for a data packet, low for a handshake |
| byte_idx_o | output | CNT_W | Index of the payload byte wanted on byte_i |
| byte_i | input | 8 | Payload byte at byte_idx_o |
| addr_wr_i | input | 1 | Load the pending address |
| addr_i | input | ADDR_W | Pending address value |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-cycle pulse after bus release |
| dev_addr_o | output | ADDR_W | Active device address |

## Verification
The main function is tried with several packet kinds. A two-byte handshake shows the address is held. All-zero payloads toggle the line every slot. Runs of 0xFF force repeated stuffing. A byte whose ones join the sync byte's final 1 checks that the run count carries across bytes. A packet ending in six ones needs a trailing stuff slot before the end of packet. A full 12-byte packet exercises the count limit. Every cycle of each packet is compared with a model built from the byte list, so a wrong bit order, a missed or misplaced stuff slot, or a wrong slot length all show up as a line mismatch. Directed cases cover the reset state, counts of 0, 1 and 13, and a start strobe injected in the middle of a packet.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_TAKE,
      S_BIT,
      S_SE0,
      S_EOPJ
   } tx_state_e;
endpackage

// File: rtl/usb_ls_slot_timer.sv
module usb_ls_slot_timer #(
   parameter int CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic double_i,
   output logic tick_o
);
   localparam int TMR_W = $clog2(2 * CLKS_PER_BIT);
   localparam logic [TMR_W-1:0] ONE_LEN = TMR_W'(CLKS_PER_BIT - 1);
   localparam logic [TMR_W-1:0] TWO_LEN = TMR_W'(2 * CLKS_PER_BIT - 1);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= double_i ? TWO_LEN : ONE_LEN;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick_o = (cnt_q == '0);

   // R4
   slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !double_i) |=> !tick_o);
endmodule

// File: rtl/usb_ls_nrzi_stuffer.sv
module usb_ls_nrzi_stuffer #(
   parameter int          MAX_BYTES = 12,
   parameter int          STUFF_RUN = 6,
   parameter logic [7:0]  SYNC_BYTE = 8'h80,
   localparam int         CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             adv_i,
   input  logic [7:0]       data_i,
   output logic             line_k_o,
   output logic             end_o,
   output logic [CNT_W-1:0] rd_idx_o
);
   localparam int RUN_W = $clog2(STUFF_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

   logic [7:0]       sh_q;
   logic [3:0]       nbits_q;
   logic [CNT_W-1:0] left_q;
   logic [RUN_W-1:0] ones_q;
   logic             line_q;
   logic [CNT_W-1:0] idx_q;

   logic       need_load;
   logic       stuff_due;
   logic [7:0] cur;

   always_comb begin
      need_load = (nbits_q == 4'd0) && (left_q != '0);
      stuff_due = (ones_q == RUN_MAX);
      cur       = need_load ? data_i : sh_q;
      end_o     = !stuff_due && (nbits_q == 4'd0) && (left_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         nbits_q <= '0;
         left_q  <= '0;
         ones_q  <= '0;
         line_q  <= 1'b0;
         idx_q   <= CNT_W'(1);
      end else if (load_i) begin
         sh_q    <= SYNC_BYTE;
         nbits_q <= 4'd8;
         left_q  <= cnt_i - 1'b1;
         ones_q  <= '0;
         line_q  <= 1'b0;
         idx_q   <= CNT_W'(1);
      end else if (adv_i && !end_o) begin
         if (stuff_due) begin
            line_q <= ~line_q;
            ones_q <= '0;
         end else begin
            sh_q    <= cur >> 1;
            nbits_q <= (need_load ? 4'd8 : nbits_q) - 4'd1;
            if (need_load) begin
               left_q <= left_q - 1'b1;
               idx_q  <= idx_q + 1'b1;
            end
            if (cur[0]) begin
               ones_q <= ones_q + 1'b1;
            end else begin
               line_q <= ~line_q;
               ones_q <= '0;
            end
         end
      end
   end

   assign line_k_o = line_q;
   assign rd_idx_o = idx_q;

   // R5
   run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RUN_MAX);

   // R5
   stuff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && stuff_due) |=> (line_q != $past(line_q)));
endmodule

// File: rtl/usb_ls_addr_hold.sv
module usb_ls_addr_hold #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wdata_i,
   input  logic              commit_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] pend_q;
   logic [ADDR_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr_i)     pend_q <= wdata_i;
         if (commit_i) act_q  <= pend_q;
      end
   end

   assign addr_o = act_q;

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(addr_o));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
   import usb_ls_tx_pkg::*;
#(
   parameter int  CLKS_PER_BIT = 8,
   parameter int  MIN_BYTES    = 2,
   parameter int  MAX_BYTES    = 12,
   parameter int  STUFF_RUN    = 6,
   parameter int  ADDR_W       = 7,
   localparam int CNT_W        = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   input  logic              data_pkt_i,
   output logic [CNT_W-1:0]  byte_idx_o,
   input  logic [7:0]        byte_i,
   input  logic              addr_wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              dp_o,
   output logic              dm_o,
   output logic              oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] dev_addr_o
);
   localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(MIN_BYTES);
   localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(MAX_BYTES);

   generate
      if (CLKS_PER_BIT < 2) begin : g_bad_bit_len
         $error("CLKS_PER_BIT must be at least 2");
      end
      if (MIN_BYTES < 2 || MAX_BYTES < MIN_BYTES) begin : g_bad_count
         $error("byte count limits must satisfy 2 <= MIN_BYTES <= MAX_BYTES");
      end
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("STUFF_RUN must be positive");
      end
   endgenerate

   tx_state_e state_q, state_d;
   logic      data_q;
   logic      done_q;
   logic      cnt_ok, accept, tick, adv, seq_end, restart, dbl, line_k, finish;

   assign cnt_ok = (byte_cnt_i >= CNT_LO) && (byte_cnt_i <= CNT_HI);
   assign accept = (state_q == S_IDLE) && start_i && cnt_ok;
   assign adv    = (state_q == S_TAKE) || ((state_q == S_BIT) && tick);
   assign finish = (state_q == S_EOPJ) && tick;
   assign restart = adv || ((state_q == S_SE0) && tick);
   assign dbl     = (state_q == S_BIT) && seq_end;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE: if (accept) state_d = S_PRE;
         S_PRE:  state_d = S_TAKE;
         S_TAKE: state_d = S_BIT;
         S_BIT:  if (tick && seq_end) state_d = S_SE0;
         S_SE0:  if (tick) state_d = S_EOPJ;
         S_EOPJ: if (tick) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         data_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept) data_q <= data_pkt_i;
      end
   end

   usb_ls_slot_timer #(
      .CLKS_PER_BIT (CLKS_PER_BIT)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .double_i  (dbl),
      .tick_o    (tick)
   );

   usb_ls_nrzi_stuffer #(
      .MAX_BYTES (MAX_BYTES),
      .STUFF_RUN (STUFF_RUN),
      .SYNC_BYTE (8'h80)
   ) u_stuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .cnt_i    (byte_cnt_i),
      .adv_i    (adv),
      .data_i   (byte_i),
      .line_k_o (line_k),
      .end_o    (seq_end),
      .rd_idx_o (byte_idx_o)
   );

   usb_ls_addr_hold #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (addr_wr_i),
      .wdata_i  (addr_i),
      .commit_i (finish && data_q),
      .addr_o   (dev_addr_o)
   );

   always_comb begin
      dp_o = 1'b0;
      dm_o = 1'b0;
      oe_o = 1'b1;
      unique case (state_q)
         S_IDLE: oe_o = 1'b0;
         S_PRE:  begin oe_o = 1'b0; dm_o = 1'b1; end
         S_TAKE: dm_o = 1'b1;
         S_BIT:  begin dp_o = line_k; dm_o = ~line_k; end
         S_SE0:  ;
         S_EOPJ: dm_o = 1'b1;
         default: oe_o = 1'b0;
      endcase
   end

   assign busy_o = (state_q != S_IDLE);
   assign done_o = done_q;

   // R8
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (state_q != S_PRE));

   // R1
   bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !cnt_ok) |=> !busy_o);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_o) |-> done_o);

   // R2
   take_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_o) |-> (dm_o && !dp_o));

   // R4
   no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dp_o && dm_o));
endmodule

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;
   localparam int BIT_CLKS = 5;
   localparam int CW = 4;
   localparam int AW = 7;
   localparam int NVEC = 7;

   // vector: [92:89] byte count, [88] data packet, [87:0] bytes 11..1 (byte 1 lowest)
   localparam logic [92:0] VEC [NVEC] = '{
      {4'd2,  1'b0, 88'hD2},
      {4'd3,  1'b1, 88'h0000},
      {4'd4,  1'b1, 88'hFFFFC3},
      {4'd2,  1'b1, 88'h3F},
      {4'd2,  1'b1, 88'hFC},
      {4'd12, 1'b1, 88'hCC330FF000FF7E8001AA55},
      {4'd3,  1'b0, 88'h5A1E}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CW-1:0] byte_cnt_i = '0;
   logic data_pkt_i = 1'b0;
   logic [CW-1:0] byte_idx_o;
   logic [7:0] byte_i;
   logic addr_wr_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic dp_o, dm_o, oe_o, busy_o, done_o;
   logic [AW-1:0] dev_addr_o;

   logic [7:0] cur_bytes [16];
   int checks = 0;
   int fails = 0;
   logic [AW-1:0] exp_addr = '0;
   int exp_sym [256];
   int exp_len;

   always #4 clk = ~clk;

   assign byte_i = cur_bytes[byte_idx_o];

   usb_ls_tx #(.CLKS_PER_BIT(BIT_CLKS)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
      .data_pkt_i(data_pkt_i), .byte_idx_o(byte_idx_o), .byte_i(byte_i),
      .addr_wr_i(addr_wr_i), .addr_i(addr_i), .dp_o(dp_o), .dm_o(dm_o),
      .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o), .dev_addr_o(dev_addr_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // line symbols: 0 = J, 1 = K, 2 = SE0
   task automatic build_model(input int cnt);
      int line, ones;
      logic [7:0] b;
      line = 0; ones = 0; exp_len = 0;
      for (int i = 0; i < cnt; i++) begin
         b = (i == 0) ? 8'h80 : cur_bytes[i];
         for (int j = 0; j < 8; j++) begin
            if (ones == 6) begin
               line = 1 - line; exp_sym[exp_len++] = line; ones = 0;
            end
            if (b[j]) ones++;
            else begin line = 1 - line; ones = 0; end
            exp_sym[exp_len++] = line;
         end
      end
      if (ones == 6) begin
         line = 1 - line; exp_sym[exp_len++] = line;
      end
      exp_sym[exp_len++] = 2;
      exp_sym[exp_len++] = 2;
      exp_sym[exp_len++] = 0;
   endtask

   task automatic write_addr(input logic [AW-1:0] a);
      @(negedge clk);
      addr_wr_i = 1'b1; addr_i = a;
      @(negedge clk);
      addr_wr_i = 1'b0;
   endtask

   task automatic run_packet(input logic [92:0] v, input bit poke, input logic [AW-1:0] pend);
      int cnt, bad, first_s;
      logic isd;
      logic [1:0] got, want;
      cnt = int'(v[92:89]);
      isd = v[88];
      for (int i = 0; i < 16; i++) cur_bytes[i] = 8'h00;
      for (int i = 1; i < cnt; i++) cur_bytes[i] = v[8*(i-1) +: 8];
      build_model(cnt);
      write_addr(pend);
      @(negedge clk);
      start_i = 1'b1; byte_cnt_i = CW'(cnt); data_pkt_i = isd;
      @(negedge clk);
      start_i = 1'b0;
      // R2: J with drivers off
      check(!oe_o && !dp_o && dm_o && busy_o, "R2 R8 pre-take", {oe_o, dp_o, dm_o, busy_o}, 4'b0011);
      @(negedge clk);
      // R2: J with drivers on
      check(oe_o && !dp_o && dm_o, "R2 take", {oe_o, dp_o, dm_o}, 3'b101);
      bad = 0; first_s = -1; got = '0; want = '0;
      for (int s = 0; s < exp_len; s++) begin
         for (int c = 0; c < BIT_CLKS; c++) begin
            @(negedge clk);
            if (poke && s == 3 && c == 0) begin
               start_i = 1'b1; byte_cnt_i = 4'd2;
            end else begin
               start_i = 1'b0;
            end
            case (exp_sym[s])
               0: want = 2'b01;
               1: want = 2'b10;
               default: want = 2'b00;
            endcase
            if ({dp_o, dm_o} != want || !oe_o || !busy_o) begin
               if (first_s < 0) begin
                  first_s = s; got = {dp_o, dm_o};
               end
               bad++;
            end
         end
      end
      start_i = 1'b0;
      // R3 R4 R5 R6 R7 R8: every cycle of the packet matches the model
      check(bad == 0, poke ? "R8 R3 R4 R5 R7 line sequence under start poke" :
                             "R3 R4 R5 R6 R7 line sequence", first_s, -1);
      if (first_s >= 0)
         $display("  first mismatch slot %0d got dp/dm=%b", first_s, got);
      @(negedge clk);
      // R7 R9 R8: released with done pulse
      check(done_o && !oe_o && !dp_o && !dm_o && !busy_o, "R7 R9 R8 release",
            {done_o, oe_o, dp_o, dm_o, busy_o}, 5'b10000);
      @(negedge clk);
      check(!done_o, "R9 single-cycle done", done_o, 0);
      if (isd) exp_addr = pend;
      // R10
      check(dev_addr_o == exp_addr, "R10 address commit", dev_addr_o, exp_addr);
   endtask

   task automatic bad_start(input logic [CW-1:0] n);
      @(negedge clk);
      start_i = 1'b1; byte_cnt_i = n; data_pkt_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      // R1
      check(!busy_o && !oe_o && !done_o, "R1 out-of-range count ignored",
            {busy_o, oe_o, done_o}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) cur_bytes[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R11 reset state while held
      check(!oe_o && !dp_o && !dm_o && !busy_o && !done_o, "R11 in reset",
            {oe_o, dp_o, dm_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!oe_o && !busy_o && !done_o && dev_addr_o == '0, "R11 R10 after reset",
            {oe_o, busy_o, done_o, dev_addr_o}, 0);

      for (int k = 0; k < NVEC; k++) begin
         run_packet(VEC[k], k == NVEC - 1, AW'(7'h10 + k));
      end

      bad_start(4'd0);
      bad_start(4'd1);
      bad_start(4'd13);
      // R10: pending write alone does not change the active address
      write_addr(7'h7F);
      @(negedge clk);
      check(dev_addr_o == exp_addr, "R10 pending not visible", dev_addr_o, exp_addr);

      summary();
      $finish;
   end
endmodule